// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits between two independent access ports, left and right, that share one memory array. Each port presents an active-low chip enable, an active-low write strobe and an address. When both ports select the same location at once, the block decides which side owns it. The losing side sees an active-low busy flag, and its write strobe toward the array is suppressed so that the location cannot be corrupted. The block does not contain the array. It only produces the gated write strobes the array consumes.

The arbiter keeps a registered copy of each port's request from the previous cycle. A port whose enable and address were already present in that copy is the earlier arrival, and it wins. When both arrive in the same cycle, the left port wins. Ownership holds for as long as the same match persists.

A mode input turns the block into a slave. In that mode the busy outputs stay high, and the per-port busy inputs act only as write inhibits. This lets several slices of a wide word follow a single master decision.

Top module: `dp_contention_arb`

## Requirements
- R1: After reset, with both enables high, both busy outputs are high and both gated write strobes are high.
- R2: In master mode, if either enable is high or the two addresses differ, both busy outputs are high after the next clock edge.
- R3: The winner depends only on enables and addresses. The state of either write strobe never changes which port gets busy.
- R4: When one port's enable and address were unchanged from the previous cycle and the other port newly arrives at the same address, the newcomer's busy output goes low after that clock edge.
- R5: When both ports arrive at the same address in the same cycle, the left port wins and only the right busy output goes low.
- R6: Ownership holds while both ports keep the same enable and address. When an address changes or an enable goes high, busy returns high after the next clock edge.
- R7: The two busy outputs are never low at the same time.
- R8: In master mode, a port's gated write strobe (wr_n = ce_n OR we_n OR blocked) is held high while its busy output is low. It is also held high in the first cycle of a contention that port loses, before busy is visible. The winner's strobe is unaffected.
- R9: In slave mode both busy outputs are high. A low busy input blocks that port's writes. A high busy input gives the normal strobe ce_n OR we_n. In master mode the busy inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_mode | input | 1 | 1 = slave (busy inputs inhibit writes), 0 = master |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_addr | input | ADDR_W | Left address |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_addr | input | ADDR_W | Right address |
| l_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| r_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_n | output | 1 | Gated left write strobe to the array, active low |
| r_wr_n | output | 1 | Gated right write strobe to the array, active low |

## Verification
Winner selection and write gating can act in the same cycle. When both ports write the same address in the cycle they first collide, the loser's strobe must already be suppressed even though its busy flag only appears after the edge. The bench provokes this with simultaneous and staggered colliding writes. It judges the strobes just after the inputs change and again just after the edge, checking that exactly one write reaches the array.

// File: rtl/dp_contention_arb.sv
module dp_contention_arb #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              l_ce_n,
  input  logic              l_we_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce_n,
  input  logic              r_we_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_n,
  output logic              r_wr_n
);
  localparam logic [1:0] OWN_NONE  = 2'd0;
  localparam logic [1:0] OWN_LEFT  = 2'd1;
  localparam logic [1:0] OWN_RIGHT = 2'd2;

  logic              l_prev_req, r_prev_req;
  logic [ADDR_W-1:0] l_prev_addr, r_prev_addr;
  logic [1:0]        own_q, own_d;

  wire l_req     = ~l_ce_n;
  wire r_req     = ~r_ce_n;
  wire hit       = l_req & r_req & (l_addr == r_addr);
  wire l_settled = l_prev_req & (l_prev_addr == l_addr) & l_req;
  wire r_settled = r_prev_req & (r_prev_addr == r_addr) & r_req;

  always_comb begin
    own_d = OWN_NONE;
    if (!slave_mode && hit) begin
      if (own_q != OWN_NONE && l_settled && r_settled)
        own_d = own_q;
      else if (r_settled && !l_settled)
        own_d = OWN_RIGHT;
      else
        own_d = OWN_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q       <= OWN_NONE;
      l_prev_req  <= 1'b0;
      r_prev_req  <= 1'b0;
      l_prev_addr <= '0;
      r_prev_addr <= '0;
    end else begin
      own_q       <= own_d;
      l_prev_req  <= l_req;
      r_prev_req  <= r_req;
      l_prev_addr <= l_addr;
      r_prev_addr <= r_addr;
    end
  end

  wire l_block = slave_mode ? ~l_busy_in_n
                            : (own_d == OWN_RIGHT) | (own_q == OWN_RIGHT);
  wire r_block = slave_mode ? ~r_busy_in_n
                            : (own_d == OWN_LEFT) | (own_q == OWN_LEFT);

  assign l_busy_n = ~(~slave_mode & (own_q == OWN_RIGHT));
  assign r_busy_n = ~(~slave_mode & (own_q == OWN_LEFT));
  assign l_wr_n   = l_ce_n | l_we_n | l_block;
  assign r_wr_n   = r_ce_n | r_we_n | r_block;
endmodule

// File: rtl/dp_contention_arb_chk.sv
module dp_contention_arb_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_mode,
  input logic              l_ce_n,
  input logic              l_we_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_ce_n,
  input logic              r_we_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_in_n,
  input logic              r_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_wr_n,
  input logic              r_wr_n
);
  wire same = !l_ce_n && !r_ce_n && (l_addr == r_addr);

  p_never_both_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !same) |=> (l_busy_n && r_busy_n));

  p_busy_gates_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !l_busy_n) |-> l_wr_n);

  p_busy_gates_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !r_busy_n) |-> r_wr_n);

  p_one_writer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && same && !l_we_n && !r_we_n) |-> (l_wr_n || r_wr_n));

  p_hold_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && same && !r_busy_n) |=>
      (slave_mode || !$stable(l_addr) || !$stable(r_addr) || l_ce_n || r_ce_n || !r_busy_n));

  p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (l_busy_n && r_busy_n));

  p_slave_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && (!l_busy_in_n || !r_busy_in_n)) |->
      ((l_busy_in_n || l_wr_n) && (r_busy_in_n || r_wr_n)));
endmodule

bind dp_contention_arb dp_contention_arb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dp_contention_arb_bench.sv
module dp_contention_arb_bench;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0, slave_mode = 0;
  logic l_ce_n = 1, l_we_n = 1, r_ce_n = 1, r_we_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_in_n = 1, r_busy_in_n = 1;
  logic l_busy_n, r_busy_n, l_wr_n, r_wr_n;
  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  dp_contention_arb #(.ADDR_W(AW)) u_dp_contention_arb (.*);

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {lb,rb,lw,rw} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive at negedge; post-edge expectation goes to the scoreboard
  task automatic step(input bit sm, input bit lce, input bit lwe, input int la,
                      input bit rce, input bit rwe, input int ra,
                      input bit lbi, input bit rbi, input logic [3:0] post,
                      input bit pre_en, input logic [1:0] pre_wr, input string tag);
    item_t it;
    @(negedge clk);
    slave_mode = sm; l_ce_n = lce; l_we_n = lwe; l_addr = AW'(la);
    r_ce_n = rce; r_we_n = rwe; r_addr = AW'(ra);
    l_busy_in_n = lbi; r_busy_in_n = rbi;
    it.exp = post; it.tag = tag;
    q.push_back(it);
    if (pre_en) begin
      #2;
      check({tag, " pre-edge"}, {2'b00, l_wr_n, r_wr_n}, {2'b00, pre_wr});
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(it.tag, {l_busy_n, r_busy_n, l_wr_n, r_wr_n}, it.exp);
        check("R7 never both busy", {2'b00, l_busy_n | r_busy_n, 1'b0}, 4'b0010);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #2 check("R1 reset state", {l_busy_n, r_busy_n, l_wr_n, r_wr_n}, 4'b1111);
    //   sm ce we addr   ce we addr  bi bi  post    pre  wr
    step(0, 1,1,0,       1,1,0,      1,1, 4'b1111, 0, 2'b11, "R1 idle");
    step(0, 0,1,5,       0,0,6,      1,1, 4'b1110, 0, 2'b11, "R2 differing addresses");
    step(0, 0,1,5,       0,0,5,      1,1, 4'b1011, 1, 2'b11, "R4 right arrives late, R8 write blocked");
    step(0, 0,0,5,       0,0,5,      1,1, 4'b1001, 0, 2'b11, "R6 hold, R3 left turns to write");
    step(0, 0,0,5,       0,0,7,      1,1, 4'b1100, 1, 2'b01, "R6 release on address change, R8 blocked while busy");
    step(0, 0,1,7,       0,0,7,      1,1, 4'b0110, 0, 2'b11, "R4 left arrives late");
    step(0, 0,0,7,       0,0,7,      1,1, 4'b0110, 0, 2'b11, "R8 busy left write blocked");
    step(0, 0,0,7,       1,1,7,      1,1, 4'b1101, 0, 2'b11, "R6 release on enable high");
    step(0, 1,1,7,       1,1,7,      1,1, 4'b1111, 0, 2'b11, "R2 idle again");
    step(0, 0,0,9,       0,0,9,      1,1, 4'b1001, 1, 2'b01, "R5 tie to left, R8 first cycle");
    step(0, 0,0,9,       0,0,9,      1,1, 4'b1001, 0, 2'b11, "R6 tie hold");
    step(0, 1,1,0,       1,1,0,      1,1, 4'b1111, 0, 2'b11, "R2 idle");
    step(0, 0,1,1023,    0,1,1023,   1,1, 4'b1011, 0, 2'b11, "R5 R3 tie with reads");
    step(1, 0,0,1023,    0,0,1023,   1,1, 4'b1100, 1, 2'b00, "R9 slave no busy out");
    step(1, 0,0,4,       0,0,8,      0,1, 4'b1110, 1, 2'b10, "R9 slave left inhibit");
    step(1, 0,0,4,       0,0,8,      1,0, 4'b1101, 1, 2'b01, "R9 slave right inhibit");
    step(0, 0,0,4,       0,0,8,      0,0, 4'b1100, 1, 2'b00, "R9 master ignores busy inputs");
    step(0, 1,1,0,       1,1,0,      1,1, 4'b1111, 0, 2'b11, "R2 final idle");
    repeat (2) @(posedge clk);
    #8;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule